// File: doc/BRIEF.md
# Command Response Capture Buffer

This block listens to the serial command line of a memory card after the host has issued a command. It collects the response the card sends back and presents it to software through a 16-bit read port, one halfword per read, most significant first. The expected response shape comes from a 2-bit response-type code latched when the command starts. The code selects no response, a 48-bit response with or without a CRC-7 check, or a 136-bit response.

A qualifying strobe marks each card-clock sample of the line. The block waits for the first sampled zero, which is the start bit. If the line stays high for a programmable number of samples, the block gives up and reports a response timeout. When the last bit of the response has been taken, the block pulses an end-of-response event and latches the CRC verdict. The captured halfwords then stay readable until the next command starts.

Top module: `cmd_resp_capture`

## Requirements
- R1: The response-type code on `resp_type` is latched on `cmd_start`. Code 0 means no response, 1 means 48 bits with CRC check, 2 means 136 bits, and 3 means 48 bits without CRC check. With code 0 the block stays idle, pulses `end_cmd_resp` in the next cycle, raises no flag and reads back zero.
- R2: Line samples are taken only in cycles with `bit_tick` high. Capture begins at the first sample that reads 0, and that start bit is the first (most significant) bit of the frame. Each later sampled bit shifts in below the earlier ones. The line value in cycles without `bit_tick` has no effect.
- R3: After a 48-bit response, three successive reads return frame bits 47:32, then 31:16, then 15:0.
- R4: After a 136-bit response, eight successive reads return frame bits 127:0, most significant halfword first, so that halfwords 2k and 2k+1 form one 32-bit word. The top 8 frame bits are not read out.
- R5: While waiting for the start bit, the block raises `resp_timeout`, pulses `end_cmd_resp` and returns to idle when the number of high line samples reaches the timeout limit.
- R6: The timeout limit is 255 after reset. A cycle with `tmo_wr` high loads `tmo_val` into the limit from the next cycle on.
- R7: For type 1 only, the block computes a CRC-7 (polynomial x^7+x^3+1, zero seed, MSB first) over frame bits 47:8. When this differs from frame bits 7:1, `resp_crc_err` is raised. Types 2 and 3 never raise it.
- R8: `end_cmd_resp` is high for exactly the one cycle after the clock edge that samples the last response bit, and `busy` is low from that cycle.
- R9: A `fifo_rd` cycle while idle advances the read pointer by one halfword. Once the pointer passes the response length the port reads zero. Reads while `busy`, or in a `cmd_start` cycle, are ignored.
- R10: `cmd_start` clears both flags, the read pointer and the previous response. A new command reads zero until its own response completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | One-cycle strobe: a command was issued, arm capture |
| resp_type | input | 2 | Response-type code, sampled with `cmd_start` |
| tmo_wr | input | 1 | Load `tmo_val` into the timeout limit |
| tmo_val | input | TO_W | New timeout limit in card-clock samples |
| bit_tick | input | 1 | Marks a cycle in which `cmd_line` is sampled |
| cmd_line | input | 1 | Serial command line from the card |
| fifo_rd | input | 1 | Read strobe of the halfword port; advances the pointer |
| fifo_data | output | 16 | Halfword at the read pointer, zero beyond the response |
| busy | output | 1 | Waiting for or receiving a response |
| resp_timeout | output | 1 | No start bit within the timeout limit |
| resp_crc_err | output | 1 | CRC-7 mismatch on a checked 48-bit response |
| end_cmd_resp | output | 1 | One-cycle end-of-response event |

## Verification
On every cycle, the assertions check that the two error flags are never both set, that a CRC error only appears for the checked type, that a command start leaves the flags clear and the pointer at zero, that an end event never coincides with `busy`, that a no-response command completes at once, and that the bit counter and read pointer stay within range. The byte order of the halfwords, the CRC verdict on good and corrupted frames, the exact timeout sample count with the reset and the programmed limit, and the immunity to line glitches between sample strobes can only be shown by the bench's scenarios. There, a behavioural model predicts every output on every clock.

// File: rtl/cmdresp_pkg.sv
package cmdresp_pkg;

    localparam int LONG_BITS  = 136;
    localparam int SHORT_BITS = 48;
    localparam int HW_BITS    = 16;
    localparam int LONG_HW    = 8;
    localparam int SHORT_HW   = 3;
    localparam int CRC_SPAN   = 40;
    localparam int CRC_W      = 7;

    typedef enum logic [1:0] {
        RT_NONE      = 2'd0,
        RT_SHORT_CRC = 2'd1,
        RT_LONG      = 2'd2,
        RT_SHORT_RAW = 2'd3
    } rtype_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WAIT  = 2'd1,
        PH_SHIFT = 2'd2
    } phase_e;

    typedef struct packed {
        logic timeout;
        logic crc_err;
    } rsp_flags_t;

    // one serial step of x^7 + x^3 + 1, message MSB first
    function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c,
                                                   input logic b);
        logic fb;
        fb = b ^ c[CRC_W-1];
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    endfunction

endpackage

// File: rtl/rsp_timer.sv
module rsp_timer #(
    parameter int TO_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            step,
    input  logic [TO_W-1:0] limit,
    output logic            expire
);
    logic [TO_W-1:0] cnt_q;

    // expires on the step that brings the count of idle samples to the limit
    assign expire = step && ({1'b0, cnt_q} + 1'b1 == {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst || clr) cnt_q <= '0;
        else if (step)  cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/rsp_shifter.sv
module rsp_shifter
    import cmdresp_pkg::*;
#(
    parameter int FRAME_W = LONG_BITS,
    parameter int SR_W    = LONG_HW * HW_BITS,
    parameter int SPAN    = CRC_SPAN,
    localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             shift,
    input  logic             bit_in,
    output logic [SR_W-1:0]  sr,
    output logic [CRC_W-1:0] crc,
    output logic [CNT_W-1:0] nbits
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sr    <= '0;
            crc   <= '0;
            nbits <= '0;
        end else if (shift) begin
            sr    <= {sr[SR_W-2:0], bit_in};
            nbits <= nbits + 1'b1;
            if (nbits < CNT_W'(SPAN))
                crc <= crc7_step(crc, bit_in);
        end
    end

    p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
        nbits <= CNT_W'(FRAME_W));
endmodule

// File: rtl/rsp_readout.sv
module rsp_readout
    import cmdresp_pkg::*;
#(
    parameter int HW_W    = HW_BITS,
    parameter int N_LONG  = LONG_HW,
    parameter int N_SHORT = SHORT_HW,
    parameter int SHORT_W = SHORT_BITS,
    localparam int SR_W   = N_LONG * HW_W,
    localparam int PTR_W  = $clog2(N_LONG + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             rd,
    input  logic             long_sel,
    input  logic             valid,
    input  logic [SR_W-1:0]  resp,
    output logic [HW_W-1:0]  data,
    output logic [PTR_W-1:0] ptr
);
    logic [HW_W-1:0]  lhw [N_LONG];
    logic [HW_W-1:0]  shw [N_SHORT];
    logic [PTR_W-1:0] len_hw;

    for (genvar g = 0; g < N_LONG; g++) begin : g_long
        assign lhw[g] = resp[SR_W-1-g*HW_W -: HW_W];
    end
    for (genvar g = 0; g < N_SHORT; g++) begin : g_short
        assign shw[g] = resp[SHORT_W-1-g*HW_W -: HW_W];
    end

    assign len_hw = !valid ? '0 : (long_sel ? PTR_W'(N_LONG) : PTR_W'(N_SHORT));

    always_comb begin
        data = '0;
        for (int i = 0; i < N_LONG; i++)
            if (valid && long_sel && ptr == PTR_W'(i)) data = lhw[i];
        for (int i = 0; i < N_SHORT; i++)
            if (valid && !long_sel && ptr == PTR_W'(i)) data = shw[i];
    end

    always_ff @(posedge clk) begin
        if (rst || clr)               ptr <= '0;
        else if (rd && ptr < len_hw)  ptr <= ptr + 1'b1;
    end

    p_ptr_bound_r9: assert property (@(posedge clk) disable iff (rst)
        ptr <= len_hw);
    p_ptr_cleared_r10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(clr)) |-> (ptr == '0));
endmodule

// File: rtl/cmd_resp_capture.sv
module cmd_resp_capture
    import cmdresp_pkg::*;
#(
    parameter int              TO_W     = 8,
    parameter logic [TO_W-1:0] TO_RESET = '1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_start,
    input  logic [1:0]      resp_type,
    input  logic            tmo_wr,
    input  logic [TO_W-1:0] tmo_val,
    input  logic            bit_tick,
    input  logic            cmd_line,
    input  logic            fifo_rd,
    output logic [15:0]     fifo_data,
    output logic            busy,
    output logic            resp_timeout,
    output logic            resp_crc_err,
    output logic            end_cmd_resp
);
    localparam int SR_W  = LONG_HW * HW_BITS;
    localparam int CNT_W = $clog2(LONG_BITS + 1);
    localparam int PTR_W = $clog2(LONG_HW + 1);

    phase_e          phase_q;
    rtype_e          type_q;
    rsp_flags_t      flags_q;
    logic [TO_W-1:0] limit_q;
    logic            end_q;
    logic            have_q;

    logic             wait_high, start_bit, shift_en, last_bit, expire, is_long;
    logic [SR_W-1:0]  sr;
    logic [CRC_W-1:0] crc;
    logic [CNT_W-1:0] nbits, frame_n;
    logic [PTR_W-1:0] ptr;

    assign is_long   = (type_q == RT_LONG);
    assign frame_n   = is_long ? CNT_W'(LONG_BITS) : CNT_W'(SHORT_BITS);
    assign wait_high = !cmd_start && phase_q == PH_WAIT && bit_tick && cmd_line;
    assign start_bit = !cmd_start && phase_q == PH_WAIT && bit_tick && !cmd_line;
    assign last_bit  = !cmd_start && phase_q == PH_SHIFT && bit_tick &&
                       (nbits + 1'b1 == frame_n);
    assign shift_en  = start_bit || (!cmd_start && phase_q == PH_SHIFT && bit_tick);

    rsp_timer #(.TO_W(TO_W)) u_timer (
        .clk(clk), .rst(rst), .clr(cmd_start), .step(wait_high),
        .limit(limit_q), .expire(expire)
    );

    rsp_shifter #(.FRAME_W(LONG_BITS), .SR_W(SR_W), .SPAN(CRC_SPAN)) u_shift (
        .clk(clk), .rst(rst), .clr(cmd_start), .shift(shift_en),
        .bit_in(cmd_line), .sr(sr), .crc(crc), .nbits(nbits)
    );

    rsp_readout #(.HW_W(HW_BITS), .N_LONG(LONG_HW), .N_SHORT(SHORT_HW),
                  .SHORT_W(SHORT_BITS)) u_read (
        .clk(clk), .rst(rst), .clr(cmd_start),
        .rd(fifo_rd && !cmd_start && phase_q == PH_IDLE),
        .long_sel(is_long), .valid(have_q), .resp(sr),
        .data(fifo_data), .ptr(ptr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            type_q  <= RT_NONE;
            flags_q <= '0;
            limit_q <= TO_RESET;
            end_q   <= 1'b0;
            have_q  <= 1'b0;
        end else begin
            end_q <= 1'b0;
            if (tmo_wr) limit_q <= tmo_val;
            if (cmd_start) begin
                type_q  <= rtype_e'(resp_type);
                flags_q <= '0;
                have_q  <= 1'b0;
                if (rtype_e'(resp_type) == RT_NONE) begin
                    phase_q <= PH_IDLE;
                    end_q   <= 1'b1;
                end else begin
                    phase_q <= PH_WAIT;
                end
            end else begin
                unique case (phase_q)
                    PH_WAIT: begin
                        if (start_bit) begin
                            phase_q <= PH_SHIFT;
                        end else if (expire) begin
                            phase_q         <= PH_IDLE;
                            flags_q.timeout <= 1'b1;
                            end_q           <= 1'b1;
                        end
                    end
                    PH_SHIFT: begin
                        if (last_bit) begin
                            phase_q <= PH_IDLE;
                            end_q   <= 1'b1;
                            have_q  <= 1'b1;
                            // before the final shift, sr[6:0] holds the CRC field
                            flags_q.crc_err <= (type_q == RT_SHORT_CRC) &&
                                               (sr[CRC_W-1:0] != crc);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign busy         = (phase_q != PH_IDLE);
    assign resp_timeout = flags_q.timeout;
    assign resp_crc_err = flags_q.crc_err;
    assign end_cmd_resp = end_q;

    p_flags_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(resp_timeout && resp_crc_err));
    p_crc_type_r7: assert property (@(posedge clk) disable iff (rst)
        resp_crc_err |-> (type_q == RT_SHORT_CRC));
    p_start_clears_r10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cmd_start)) |-> (!resp_timeout && !resp_crc_err));
    p_end_idle_r8: assert property (@(posedge clk) disable iff (rst)
        end_cmd_resp |-> !busy);
    p_none_done_r1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cmd_start) && $past(resp_type) == 2'd0)
        |-> (!busy && end_cmd_resp));
endmodule

// File: tb/cmd_resp_capture_bench.sv
`timescale 1ns/1ps
module cmd_resp_capture_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_start = 1'b0;
    logic [1:0]  resp_type = 2'd0;
    logic        tmo_wr = 1'b0;
    logic [7:0]  tmo_val = 8'd0;
    logic        bit_tick = 1'b0;
    logic        cmd_line = 1'b1;
    logic        fifo_rd = 1'b0;
    logic [15:0] fifo_data;
    logic        busy, resp_timeout, resp_crc_err, end_cmd_resp;

    always #2 clk = ~clk;

    cmd_resp_capture u_cmd_resp_capture (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .resp_type(resp_type),
        .tmo_wr(tmo_wr), .tmo_val(tmo_val), .bit_tick(bit_tick),
        .cmd_line(cmd_line), .fifo_rd(fifo_rd), .fifo_data(fifo_data),
        .busy(busy), .resp_timeout(resp_timeout), .resp_crc_err(resp_crc_err),
        .end_cmd_resp(end_cmd_resp)
    );

    int    vectors = 0;
    int    miscompares = 0;
    int    cycles = 0;
    string cur_req = "R6";

    function automatic logic [6:0] crc_bit(input logic [6:0] c, input logic b);
        logic fb;
        fb = b ^ c[6];
        return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    endfunction

    // ---------------- behavioural reference ----------------
    int          m_phase;   // 0 idle, 1 waiting, 2 receiving
    int          m_type, m_limit, m_wait, m_ptr;
    bit          m_to, m_ce, m_end;
    bit          m_bits[$];
    logic [15:0] m_hw[$];

    task automatic model_finish();
        logic [135:0] f;
        logic [6:0]   c;
        f = '0;
        c = '0;
        foreach (m_bits[i]) f = {f[134:0], m_bits[i]};
        for (int i = 0; i < 40; i++) c = crc_bit(c, m_bits[i]);
        if (m_type == 2) for (int k = 0; k < 8; k++) m_hw.push_back(f[127-16*k -: 16]);
        else             for (int k = 0; k < 3; k++) m_hw.push_back(f[47-16*k -: 16]);
        m_ce = (m_type == 1) && (f[7:1] != c);
        m_end = 1;
        m_phase = 0;
    endtask

    always @(posedge clk) begin
        int old_limit;
        bit idle_pre;
        m_end = 0;
        if (rst) begin
            m_phase = 0; m_type = 0; m_limit = 255; m_wait = 0; m_ptr = 0;
            m_to = 0; m_ce = 0;
            m_bits.delete(); m_hw.delete();
        end else begin
            old_limit = m_limit;
            idle_pre  = (m_phase == 0);
            if (!cmd_start && idle_pre && fifo_rd && m_ptr < m_hw.size()) m_ptr++;
            if (cmd_start) begin
                m_type = resp_type; m_to = 0; m_ce = 0; m_ptr = 0; m_wait = 0;
                m_bits.delete(); m_hw.delete();
                if (resp_type == 0) begin m_phase = 0; m_end = 1; end
                else m_phase = 1;
            end else if (!idle_pre && bit_tick) begin
                if (m_phase == 1) begin
                    if (!cmd_line) begin m_bits.push_back(1'b0); m_phase = 2; end
                    else begin
                        m_wait++;
                        if (m_wait == old_limit) begin m_to = 1; m_end = 1; m_phase = 0; end
                    end
                end else begin
                    m_bits.push_back(cmd_line);
                    if (m_bits.size() == ((m_type == 2) ? 136 : 48)) model_finish();
                end
            end
            if (tmo_wr) m_limit = tmo_val;
        end
    end

    task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            chk("busy",         {15'd0, busy},         {15'd0, m_phase != 0});
            chk("end_cmd_resp", {15'd0, end_cmd_resp}, {15'd0, m_end});
            chk("resp_timeout", {15'd0, resp_timeout}, {15'd0, m_to});
            chk("resp_crc_err", {15'd0, resp_crc_err}, {15'd0, m_ce});
            chk("fifo_data",    fifo_data, (m_ptr < m_hw.size()) ? m_hw[m_ptr] : 16'h0);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            miscompares++;
            $display("FAIL watchdog %s: actual hung expected done", cur_req);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    function automatic logic [135:0] short_frame(input logic [5:0] idx,
                                                 input logic [31:0] arg,
                                                 input bit corrupt);
        logic [135:0] f;
        logic [6:0]   c;
        f = '0;
        c = '0;
        f[47:8] = {2'b00, idx, arg};
        for (int i = 47; i >= 8; i--) c = crc_bit(c, f[i]);
        f[7:1] = corrupt ? (c ^ 7'h10) : c;
        f[0] = 1'b1;
        return f;
    endfunction

    task automatic issue(input logic [1:0] t);
        @(negedge clk); cmd_start = 1'b1; resp_type = t;
        @(negedge clk); cmd_start = 1'b0;
    endtask

    // gap high samples, then n frame bits MSB first; one sample every div cycles,
    // with the line pulled low in the cycles between samples
    task automatic card_bits(input logic [135:0] f, input int n, input int gap, input int div);
        for (int i = 0; i < gap + n; i++) begin
            for (int d = 0; d < div; d++) begin
                @(negedge clk);
                bit_tick = (d == div - 1);
                cmd_line = bit_tick ? ((i < gap) ? 1'b1 : f[n - 1 - (i - gap)]) : 1'b0;
            end
        end
        @(negedge clk); bit_tick = 1'b0; cmd_line = 1'b1;
    endtask

    task automatic reads(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); fifo_rd = 1'b1;
            @(negedge clk); fifo_rd = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [135:0] lf;
        idle(3);
        @(negedge clk); rst = 1'b0;
        cur_req = "R6";   // reset state checked on every cycle from here
        idle(3);

        cur_req = "R3";   // good checked short response, then over-read (R9)
        issue(2'd1);
        card_bits(short_frame(6'h11, 32'hCAFE_1234, 1'b0), 48, 3, 1);
        idle(2);
        cur_req = "R9";
        reads(5);

        cur_req = "R7";   // corrupted CRC on the checked type
        issue(2'd1);
        card_bits(short_frame(6'h05, 32'h0000_FFFF, 1'b1), 48, 1, 1);
        idle(2); reads(3);

        cur_req = "R1";   // unchecked short type ignores a bad CRC
        issue(2'd3);
        card_bits(short_frame(6'h3F, 32'h8000_0001, 1'b1), 48, 0, 1);
        idle(2); reads(3);

        cur_req = "R4";   // long response, sparse samples, glitches between them (R2)
        lf = {8'h3F, 32'hDEAD_BEEF, 32'h1234_5678, 32'hA5A5_0F0F, 32'h0123_4567};
        issue(2'd2);
        card_bits(lf, 136, 4, 3);
        idle(2); reads(9);

        cur_req = "R1";   // no response expected
        issue(2'd0);
        idle(3); reads(2);

        cur_req = "R10";  // new command clears old data; reads while busy ignored
        issue(2'd1);
        card_bits(short_frame(6'h2A, 32'h5555_AAAA, 1'b0), 48, 2, 1);
        idle(1); reads(1);
        issue(2'd1);
        reads(2);
        cur_req = "R8";
        card_bits(short_frame(6'h01, 32'h0F0F_F0F0, 1'b0), 48, 0, 2);
        idle(2); reads(3);

        cur_req = "R5";   // reset limit of 255 high samples
        issue(2'd1);
        @(negedge clk); bit_tick = 1'b1; cmd_line = 1'b1;
        idle(260);
        @(negedge clk); bit_tick = 1'b0;
        reads(2);

        cur_req = "R6";   // programmed limit
        @(negedge clk); tmo_wr = 1'b1; tmo_val = 8'd6;
        @(negedge clk); tmo_wr = 1'b0;
        issue(2'd2);
        @(negedge clk); bit_tick = 1'b1; cmd_line = 1'b1;
        idle(10);
        @(negedge clk); bit_tick = 1'b0;
        idle(2);

        cur_req = "R2";   // start bit right after a short wait under the new limit
        issue(2'd3);
        card_bits(short_frame(6'h0C, 32'h7777_1111, 1'b0), 48, 5, 1);
        idle(2); reads(3);

        idle(4);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule